// File: doc/BRIEF.md
# DC Offset Canceller for I/Q Sample Streams

This block strips a constant bias from a stream of signed 12-bit I/Q samples. For each channel it sums a run of valid input samples (a window of 32, 64, 128 or 256 samples), divides the sum by the window length with an arithmetic right shift, and keeps the result as that channel's offset estimate. The current estimate is subtracted from every valid sample. The difference is clipped to the 12-bit signed range and registered.

A 2-bit mode input picks how the block behaves. It can pass samples through untouched. It can track the offset continuously. Or it can track the offset only while the receiver is searching for a frame: a sync-found pulse holds the estimate and the partly filled window, and a resume-search pulse starts a fresh window. The estimate in use keeps being subtracted while it is held.

Top module: `dc_offset_remover`

## Requirements
- R1: The window code `win_code` sets the window length N: 0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256. After N accumulated samples, the estimate becomes floor(sum/N), which is the sum shifted arithmetically right by log2(N). The accumulator then restarts from zero. The new estimate applies from the next valid sample onward.
- R2: Mode 0 (`mode`=2'b00) is pass-through. Each valid sample appears unchanged on the output.
- R3: Mode 3 (`mode`=2'b11) is reserved and behaves exactly as pass-through.
- R4: Mode 1 (`mode`=2'b01) tracks continuously. Each valid output is the input minus the current estimate, and the estimate is renewed at the end of every window.
- R5: In mode 2 (`mode`=2'b10), a cycle with `sync_found` high freezes the block. The sample in that cycle is not accumulated. While frozen, the accumulator, the sample count and the estimate all hold, and the held estimate is still subtracted.
- R6: In mode 2, `search_resume` high while frozen (and `sync_found` low) unfreezes the block. The accumulator and count restart from zero, and the sample in that cycle is not accumulated, so a full new window follows. `search_resume` has no effect when the block is not frozen.
- R7: Any cycle in which `win_code` differs from its value in the previous cycle restarts the window from zero, and that cycle's sample is not accumulated. After reset, the previous code is taken as 0.
- R8: When the difference falls outside the output range, it saturates to -2048 or +2047.
- R9: The output has one cycle of latency. `out_valid` is `in_valid` delayed by one cycle, and the output data hold their value in cycles that follow an invalid input.
- R10: During and after reset, the estimates are zero and `out_valid`, `out_i` and `out_q` are zero.
- R11: Cycles with `in_valid` low neither add to the accumulator nor advance the window count.
- R12: In modes 0 and 3, the accumulator and count are cleared and any freeze is released, so returning to mode 1 or 2 starts a full new window. The last estimate is kept and applies again on return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| win_code | input | 2 | Window length code (32 << code samples) |
| mode | input | 2 | 00 pass, 01 track, 10 track until sync, 11 pass |
| sync_found | input | 1 | Frame sync detected (freezes in mode 2) |
| search_resume | input | 1 | Receiver back to frame search (unfreezes in mode 2) |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Corrected in-phase sample |
| out_q | output | 12 | Corrected quadrature sample |

## Verification
Pass-through is swept across the whole 12-bit input range in both pass codes. Each window length is driven with a distinct offset plus a small deterministic ripple, with every fifth cycle left idle. This separates the correct window length and the floor rounding of negative means from an off-by-one count or from idle cycles being counted. Dedicated sequences push the difference past both rails, change the window code partway through a window, and pulse sync and resume. They also cover a resume while not frozen and a partial window cut short by pass mode. These show whether a held or restarted window leaks stale samples into the next estimate.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;

  typedef enum logic [1:0] {
    DCR_PASS  = 2'b00,
    DCR_TRACK = 2'b01,
    DCR_GATED = 2'b10,
    DCR_RSVD  = 2'b11
  } dcr_mode_e;

endpackage

// File: rtl/dcr_window_ctrl.sv
`timescale 1ns/1ps
module dcr_window_ctrl
  import dcr_pkg::*;
#(
  parameter int MIN_LOG2 = 5,
  parameter int CODE_W   = 2,
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << CODE_W) - 1,
  localparam int CNT_W    = MAX_LOG2,
  localparam int SH_W     = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] win_code_i,
  input  logic              sample_vld_i,
  input  logic              sync_found_i,
  input  logic              search_resume_i,
  output logic              acc_clr_o,
  output logic              acc_en_o,
  output logic              dump_o,
  output logic [SH_W-1:0]   shift_o,
  output logic              est_active_o
);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              frz_q, frz_d;
  logic              active, gated, code_chg;
  logic              set_fz, clr_fz, hold, clr, en, dump;
  logic [CNT_W-1:0]  last_now;
  dcr_mode_e         mode_e;

  function automatic logic [CNT_W-1:0] win_last(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << (MIN_LOG2 + int'(c));
    return CNT_W'(span - (CNT_W+1)'(1));
  endfunction

  // next-state logic
  always_comb begin
    mode_e   = dcr_mode_e'(mode_i);
    active   = (mode_e == DCR_TRACK) || (mode_e == DCR_GATED);
    gated    = (mode_e == DCR_GATED);
    code_chg = (win_code_i != code_q);
    set_fz   = gated & sync_found_i;
    clr_fz   = gated & frz_q & search_resume_i & ~sync_found_i;
    hold     = set_fz | (gated & frz_q & ~clr_fz);
    clr      = ~active | clr_fz | code_chg;
    en       = ~clr & ~hold & sample_vld_i;
    last_now = win_last(win_code_i);
    dump     = en & (cnt_q == last_now);

    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = dump ? '0 : cnt_q + CNT_W'(1);
    end

    if (!gated)      frz_d = 1'b0;
    else if (set_fz) frz_d = 1'b1;
    else if (clr_fz) frz_d = 1'b0;
    else             frz_d = frz_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
      frz_q  <= 1'b0;
    end else begin
      code_q <= win_code_i;
      cnt_q  <= cnt_d;
      frz_q  <= frz_d;
    end
  end

  assign acc_clr_o    = clr;
  assign acc_en_o     = en;
  assign dump_o       = dump;
  assign shift_o      = SH_W'(MIN_LOG2) + SH_W'(win_code_i);
  assign est_active_o = active;

  // R1: the count never leaves the window selected by the registered code
  assert_count_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= win_last(code_q));

  // R5: frozen and undisturbed means the count holds
  assert_freeze_holds_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && frz_q && !search_resume_i && !code_chg) |=> $stable(cnt_q));

  // R6: a resume while frozen empties the window and unfreezes
  assert_resume_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && frz_q && search_resume_i && !sync_found_i) |=> (cnt_q == '0 && !frz_q));

  // R12: pass modes leave no partial window and no freeze behind
  assert_pass_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0 && !frz_q));

endmodule

// File: rtl/dcr_chan_est.sv
`timescale 1ns/1ps
module dcr_chan_est #(
  parameter int DW    = 12,
  parameter int ACC_W = 20,
  parameter int SH_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_i,
  input  logic                 acc_clr_i,
  input  logic                 acc_en_i,
  input  logic                 dump_i,
  input  logic [SH_W-1:0]      shift_i,
  output logic signed [DW-1:0] est_o
);

  logic signed [ACC_W-1:0] acc_q, acc_d, sum;
  logic signed [DW-1:0]    est_q, est_d;

  assign sum = acc_q + ACC_W'(x_i);

  always_comb begin
    acc_d = acc_q;
    est_d = est_q;
    if (acc_clr_i) begin
      acc_d = '0;
    end else if (acc_en_i) begin
      if (dump_i) begin
        acc_d = '0;
        est_d = DW'(sum >>> shift_i);
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      est_q <= '0;
    end else begin
      acc_q <= acc_d;
      est_q <= est_d;
    end
  end

  assign est_o = est_q;

  // R7: a restart leaves the accumulator empty
  assert_clear_empties_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_i |=> (acc_q == '0));

  // R5: the estimate moves only at the end of a window
  assert_est_moves_on_dump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en_i && dump_i && !acc_clr_i) |=> $stable(est_q));

endmodule

// File: rtl/dcr_sub_sat.sv
`timescale 1ns/1ps
module dcr_sub_sat #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic                 est_active_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] est_i,
  output logic signed [DW-1:0] y_o
);

  logic signed [DW:0]   diff;
  logic signed [DW-1:0] sat_val, y_d, y_q;

  always_comb begin
    diff = {x_i[DW-1], x_i} - {est_i[DW-1], est_i};
    if (diff[DW] != diff[DW-1]) begin
      sat_val = diff[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    end else begin
      sat_val = diff[DW-1:0];
    end
    y_d = y_q;
    if (vld_i) begin
      y_d = est_active_i ? sat_val : x_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  assign y_o = y_q;

  // R2: with cancellation off, a valid sample is copied straight through
  assert_bypass_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !est_active_i) |=> (y_q == $past(x_i)));

  // R9: data hold after an idle input cycle
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(y_q));

endmodule

// File: rtl/dc_offset_remover.sv
`timescale 1ns/1ps
module dc_offset_remover #(
  parameter int DATA_W       = 12,
  parameter int WIN_MIN_LOG2 = 5,
  parameter int WIN_CODE_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_i,
  input  logic [DATA_W-1:0]     in_q,
  input  logic [WIN_CODE_W-1:0] win_code,
  input  logic [1:0]            mode,
  input  logic                  sync_found,
  input  logic                  search_resume,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_i,
  output logic [DATA_W-1:0]     out_q
);

  localparam int NCH      = 2;
  localparam int MAX_LOG2 = WIN_MIN_LOG2 + (1 << WIN_CODE_W) - 1;
  localparam int ACC_W    = DATA_W + MAX_LOG2;
  localparam int SH_W     = $clog2(MAX_LOG2 + 1);

  logic                     acc_clr, acc_en, dump, est_active;
  logic [SH_W-1:0]          shift;
  logic signed [DATA_W-1:0] x_ch   [NCH];
  logic signed [DATA_W-1:0] est_ch [NCH];
  logic signed [DATA_W-1:0] y_ch   [NCH];
  logic                     vld_q, vld_d;

  assign x_ch[0] = $signed(in_i);
  assign x_ch[1] = $signed(in_q);

  dcr_window_ctrl #(
    .MIN_LOG2 (WIN_MIN_LOG2),
    .CODE_W   (WIN_CODE_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode),
    .win_code_i      (win_code),
    .sample_vld_i    (in_valid),
    .sync_found_i    (sync_found),
    .search_resume_i (search_resume),
    .acc_clr_o       (acc_clr),
    .acc_en_o        (acc_en),
    .dump_o          (dump),
    .shift_o         (shift),
    .est_active_o    (est_active)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dcr_chan_est #(
      .DW    (DATA_W),
      .ACC_W (ACC_W),
      .SH_W  (SH_W)
    ) u_est (
      .clk       (clk),
      .rst_n     (rst_n),
      .x_i       (x_ch[ch]),
      .acc_clr_i (acc_clr),
      .acc_en_i  (acc_en),
      .dump_i    (dump),
      .shift_i   (shift),
      .est_o     (est_ch[ch])
    );

    dcr_sub_sat #(
      .DW (DATA_W)
    ) u_sub (
      .clk          (clk),
      .rst_n        (rst_n),
      .vld_i        (in_valid),
      .est_active_i (est_active),
      .x_i          (x_ch[ch]),
      .est_i        (est_ch[ch]),
      .y_o          (y_ch[ch])
    );
  end

  always_comb vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign out_i     = y_ch[0];
  assign out_q     = y_ch[1];

  // R9: the output strobe trails the input strobe by one cycle
  assert_valid_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: tb/dc_offset_remover_bench.sv
`timescale 1ns/1ps
module dc_offset_remover_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_i, in_q;
  logic [1:0]  win_code;
  logic [1:0]  mode;
  logic        sync_found, search_resume;
  logic        out_valid;
  logic [11:0] out_i, out_q;

  int vectors = 0;
  int miscompares = 0;

  // reference state, derived from the requirements
  int m_acc_i, m_acc_q, m_cnt, m_est_i, m_est_q, m_code;
  bit m_frz;
  int e_i, e_q;
  bit e_v;

  always #2.5 clk = ~clk;

  dc_offset_remover u_dc_offset_remover (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_i          (in_i),
    .in_q          (in_q),
    .win_code      (win_code),
    .mode          (mode),
    .sync_found    (sync_found),
    .search_resume (search_resume),
    .out_valid     (out_valid),
    .out_i         (out_i),
    .out_q         (out_q)
  );

  function automatic int clip(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int ripple(input int k);
    return ((k * 37) % 61) - 30;
  endfunction

  task automatic check_out(input string tag);
    int gi, gq;
    gi = int'($signed(out_i));
    gq = int'($signed(out_q));
    vectors++;
    if (out_valid !== e_v || gi != e_i || gq != e_q) begin
      miscompares++;
      $display("FAIL %s: valid/i/q got %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, out_valid, gi, gq, e_v, e_i, e_q);
    end
  endtask

  // one input cycle: drive, predict, clock, compare
  task automatic step(input bit v, input int xi, input int xq,
                      input bit sy, input bit rs, input string tag);
    bit act, gated, set_fz, clr_fz, hold, clr;
    int n, sh;
    in_valid      = v;
    in_i          = xi[11:0];
    in_q          = xq[11:0];
    sync_found    = sy;
    search_resume = rs;
    act   = (mode == 2'b01) || (mode == 2'b10);
    gated = (mode == 2'b10);
    if (v) begin
      e_i = act ? clip(xi - m_est_i) : xi;
      e_q = act ? clip(xq - m_est_q) : xq;
    end
    e_v    = v;
    set_fz = gated && sy;
    clr_fz = gated && m_frz && rs && !sy;
    hold   = set_fz || (gated && m_frz && !clr_fz);
    clr    = !act || clr_fz || (int'(win_code) != m_code);
    sh     = 5 + int'(win_code);
    n      = 1 << sh;
    if (clr) begin
      m_acc_i = 0; m_acc_q = 0; m_cnt = 0;
    end else if (!hold && v) begin
      m_acc_i += xi;
      m_acc_q += xq;
      if (m_cnt == n - 1) begin
        m_est_i = m_acc_i >>> sh;
        m_est_q = m_acc_q >>> sh;
        m_acc_i = 0; m_acc_q = 0; m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
    if (!gated)      m_frz = 1'b0;
    else if (set_fz) m_frz = 1'b1;
    else if (clr_fz) m_frz = 1'b0;
    m_code = int'(win_code);
    @(posedge clk);
    #1;
    check_out(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R9: watchdog expired, got still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    win_code = 2'd0; mode = 2'b01; sync_found = 1'b0; search_resume = 1'b0;
    m_acc_i = 0; m_acc_q = 0; m_cnt = 0; m_est_i = 0; m_est_q = 0;
    m_code = 0; m_frz = 1'b0; e_i = 0; e_q = 0; e_v = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_out("R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R10: estimate starts at zero, so the first samples come through intact
    step(1, 321, -654, 0, 0, "R10 zero estimate");
    step(0, 5, 5, 0, 0, "R9 idle hold");
    step(1, -7, 9, 0, 0, "R10 zero estimate");

    // R2: pass-through across the full range
    mode = 2'b00;
    for (int v = -2048; v <= 2047; v += 7) step(1, v, -1 - v, 0, 0, "R2 pass sweep");
    // R3: reserved code behaves the same
    mode = 2'b11;
    for (int v = 2047; v >= -2048; v -= 13) step(1, v, v / 2, 0, 0, "R3 reserved sweep");

    // R1 R4 R11: every window length, offset plus ripple, with idle gaps
    mode = 2'b01;
    for (int c = 0; c < 4; c++) begin
      win_code = c[1:0];
      for (int k = 0; k < (64 << c) + 9; k++)
        step((k % 5) != 3, clip(150 * c - 233 + ripple(k)),
             clip(61 - 90 * c + ripple(k + 11)), 0, 0, "R1 R4 R11 window sweep");
    end

    // R7: a code change mid-window discards the partial sum
    win_code = 2'd0;
    for (int k = 0; k < 20; k++) step(1, 1000, -900, 0, 0, "R7 partial window");
    win_code = 2'd1;
    for (int k = 0; k < 70; k++) step(1, -100 + (k % 3), 77, 0, 0, "R7 restarted window");

    // R8: push the difference past both rails
    win_code = 2'd0;
    for (int k = 0; k < 40; k++) step(1, 2000, -2000, 0, 0, "R8 build large estimate");
    step(1, -2048, 2047, 0, 0, "R8 saturate");
    step(1, -1, 1, 0, 0, "R8 saturate");
    for (int k = 0; k < 40; k++) step(1, -2000, 2000, 0, 0, "R8 flip estimate");
    step(1, 2047, -2048, 0, 0, "R8 saturate other rail");

    // R5 R6: freeze on sync, resume on search
    mode = 2'b10;
    for (int k = 0; k < 45; k++) step(1, 300 + ripple(k), -250, 0, 0, "R5 gated tracking");
    step(1, 999, 999, 0, 1, "R6 resume while not frozen ignored");
    step(1, 800, -800, 1, 0, "R5 sync freezes");
    for (int k = 0; k < 100; k++) step((k % 4) != 0, -500, 400 + ripple(k), 0, 0, "R5 frozen estimate held");
    step(1, 1500, 1500, 1, 1, "R5 sync with resume stays frozen");
    step(1, 1700, -1700, 0, 1, "R6 resume");
    for (int k = 0; k < 40; k++) step(1, -500 + ripple(k), 400, 0, 0, "R6 full new window");

    // R12: pass mode drops the partial window, keeps the estimate, drops the freeze
    mode = 2'b01;
    for (int k = 0; k < 20; k++) step(1, 800, -600, 0, 0, "R12 partial window");
    mode = 2'b00;
    for (int k = 0; k < 3; k++) step(1, 11, 22, 0, 0, "R12 pass interlude");
    mode = 2'b01;
    for (int k = 0; k < 40; k++) step(1, ripple(k), 5, 0, 0, "R12 fresh window");
    mode = 2'b10;
    step(1, 50, 50, 1, 0, "R12 freeze before pass");
    mode = 2'b11;
    step(1, 60, 60, 0, 0, "R12 pass releases freeze");
    mode = 2'b10;
    for (int k = 0; k < 40; k++) step(1, 700, -700, 0, 0, "R12 tracking after release");
    step(0, 0, 0, 0, 0, "R9 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule